// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the instruction fetch address of a small microcontroller core that uses 12-bit instruction words. Once per instruction cycle, when the advance enable is high, it either steps the address by one or loads a jump target. The jump target takes its low nine bits from the instruction's target field. Its upper two bits come from a page-select register, which the core writes through a separate port. Program memory holds 2048 words in four pages of 512 words each.

Reset sets the address to the highest word of memory and clears the page-select bits to page 0. A jump placed at that highest word therefore lands in page 0. Straight-line execution from it wraps to address 0.

A mode input marks devices that have an internal oscillator. On such devices the word at the top address is a calibration literal load and is always executed first. Execution then continues at address 0, and a jump request is not honoured on that word. The block raises a flag while that calibration word is being fetched. Decoding, the call stack, the ALU and the working register are outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is sampled low, the next state is fetch address 0x7FF (the highest word) and page bits 0, whatever the previous page value was.
- R2: When `adv_en` is low, the fetch address keeps its value on the next clock.
- R3: When `adv_en` is high and `jmp_strobe` is low, the fetch address becomes the previous address plus one, and 0x7FF is followed by 0x000.
- R4: When `adv_en` and `jmp_strobe` are both high, the next fetch address is {page bits, `jmp_field`}: page bits in address bits 10:9 and the field in bits 8:0. A jump takes priority over the increment.
- R5: A jump executed at the reset vector with no page write since reset lands in page 0, at address `jmp_field`.
- R6: A page write loads `pg_wdata` into the page bits on the next clock and leaves the fetch address unchanged. A jump in the same cycle as a page write uses the page value from before the write.
- R7: `cal_fetch` is high exactly when `osc_mode` is high, the fetch address is 0x7FF and no advance has happened since reset. It is low in every other case.
- R8: With `osc_mode` high, the first advance after reset always moves to address 0x000, even when `jmp_strobe` is high.
- R9: `jmp_strobe` has no effect on the fetch address while `adv_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_mode | input | 1 | High on devices with an internal oscillator (calibration word first) |
| adv_en | input | 1 | Advance the counter this cycle |
| jmp_strobe | input | 1 | Load a jump target instead of incrementing |
| jmp_field | input | 9 | Low address bits of the jump target |
| pg_wr | input | 1 | Write strobe for the page-select bits |
| pg_wdata | input | 2 | New page-select value |
| fetch_addr | output | 11 | Program memory fetch address |
| page_sel | output | 2 | Current page-select bits |
| cal_fetch | output | 1 | High while the calibration word is being fetched |

## Verification
The properties assume that `osc_mode` is held steady from reset until the first advance. They also assume that the inputs are known whenever reset is high, since the page and address checks compare against the previous cycle's inputs. The stimulus changes `osc_mode` only while reset is low and drives every input on the falling edge. This keeps each sampled value clean for both the properties and the bench's own comparisons.

// File: rtl/pcseq_pkg.sv
// Package: shared sizes and types for the paged program counter sequencer.
// Assumes power-of-two memory with page bits forming the top address bits.
package pcseq_pkg;
    localparam int DEF_ADDR_W = 11;
    localparam int DEF_PAGE_W = 2;

    // Source of the next fetch address
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_INCR = 2'd1,
        SRC_JUMP = 2'd2
    } next_src_e;
endpackage

// File: rtl/pcseq_page_reg.sv
// Module: page-select register.
// Holds the page bits used as the upper part of jump targets. A write takes
// effect on the next clock; reset clears to page 0.
module pcseq_page_reg #(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_data,
    output logic [PAGE_W-1:0] page_q
);
    // Load on write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (wr_en)
            page_q <= wr_data;
    end
endmodule

// File: rtl/pcseq_cal_track.sv
// Module: calibration fetch tracker.
// Remembers whether any advance has occurred since reset. Assumes osc_mode is
// static from reset until the first advance.
module pcseq_cal_track #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_mode,
    input  logic              adv_en,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              first_word
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    logic fresh_q;

    // Set at reset, cleared on the first advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            fresh_q <= 1'b1;
        else if (adv_en)
            fresh_q <= 1'b0;
    end

    // Calibration word is the top word, fetched before any advance
    always_comb first_word = fresh_q && osc_mode && (cur_addr == TOP);
endmodule

// File: rtl/pcseq_next_sel.sv
// Module: next-address selector (combinational).
// Chooses hold, increment or jump; builds the jump target from the page bits
// and the instruction field. The calibration word always falls through.
module pcseq_next_sel
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 2
) (
    input  logic                     adv_en,
    input  logic                     jmp_strobe,
    input  logic                     cal_word,
    input  logic [ADDR_W-PAGE_W-1:0] jmp_field,
    input  logic [PAGE_W-1:0]        page_bits,
    input  logic [ADDR_W-1:0]        cur_addr,
    output next_src_e                src,
    output logic [ADDR_W-1:0]        next_addr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Pick the source: jump wins over increment, except on the calibration word
    always_comb begin
        if (!adv_en)
            src = SRC_HOLD;
        else if (jmp_strobe && !cal_word)
            src = SRC_JUMP;
        else
            src = SRC_INCR;
    end

    // Form the next address; the increment wraps naturally at the top
    always_comb begin
        case (src)
            SRC_INCR: next_addr = cur_addr + ONE;
            SRC_JUMP: next_addr = {page_bits, jmp_field};
            default:  next_addr = cur_addr;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
// Module: paged program counter sequencer (top).
// Holds the fetch address, applies the top-of-memory reset vector with page 0,
// and steps or jumps once per enabled instruction cycle.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int PAGE_W = DEF_PAGE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     osc_mode,
    input  logic                     adv_en,
    input  logic                     jmp_strobe,
    input  logic [ADDR_W-PAGE_W-1:0] jmp_field,
    input  logic                     pg_wr,
    input  logic [PAGE_W-1:0]        pg_wdata,
    output logic [ADDR_W-1:0]        fetch_addr,
    output logic [PAGE_W-1:0]        page_sel,
    output logic                     cal_fetch
);
    localparam logic [ADDR_W-1:0] RESET_VEC = '1;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic [PAGE_W-1:0] page_q;
    logic              cal_word;
    next_src_e         src;

    pcseq_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pg_wr),
        .wr_data (pg_wdata),
        .page_q  (page_q)
    );

    pcseq_cal_track #(.ADDR_W(ADDR_W)) u_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_mode   (osc_mode),
        .adv_en     (adv_en),
        .cur_addr   (pc_q),
        .first_word (cal_word)
    );

    pcseq_next_sel #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_next (
        .adv_en     (adv_en),
        .jmp_strobe (jmp_strobe),
        .cal_word   (cal_word),
        .jmp_field  (jmp_field),
        .page_bits  (page_q),
        .cur_addr   (pc_q),
        .src        (src),
        .next_addr  (pc_d)
    );

    // Program counter register with top-of-memory reset vector
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_VEC;
        else
            pc_q <= pc_d;
    end

    // Drive outputs
    always_comb begin
        fetch_addr = pc_q;
        page_sel   = page_q;
        cal_fetch  = cal_word;
    end
endmodule

// File: rtl/pc_sequencer_chk.sv
// Module: property checker for pc_sequencer, attached by bind.
// Assumes osc_mode is steady from reset until the first advance.
module pc_sequencer_chk #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     osc_mode,
    input logic                     adv_en,
    input logic                     jmp_strobe,
    input logic [ADDR_W-PAGE_W-1:0] jmp_field,
    input logic                     pg_wr,
    input logic [PAGE_W-1:0]        pg_wdata,
    input logic [ADDR_W-1:0]        fetch_addr,
    input logic [PAGE_W-1:0]        page_sel,
    input logic                     cal_fetch
);
    localparam logic [ADDR_W-1:0] TOP = '1;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    p_reset_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fetch_addr == TOP && page_sel == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(fetch_addr));

    p_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !jmp_strobe) |=> fetch_addr == $past(fetch_addr) + ONE);

    p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && jmp_strobe && !cal_fetch) |=>
            fetch_addr == {$past(page_sel), $past(jmp_field)});

    p_page_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pg_wr |=> page_sel == $past(pg_wdata));

    p_page_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_wr |=> $stable(page_sel));

    p_cal_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fetch |-> (osc_mode && fetch_addr == TOP));

    p_cal_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> !cal_fetch);

    p_cal_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_fetch && adv_en) |=> fetch_addr == '0);
endmodule

bind pc_sequencer pc_sequencer_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_mode   (osc_mode),
    .adv_en     (adv_en),
    .jmp_strobe (jmp_strobe),
    .jmp_field  (jmp_field),
    .pg_wr      (pg_wr),
    .pg_wdata   (pg_wdata),
    .fetch_addr (fetch_addr),
    .page_sel   (page_sel),
    .cal_fetch  (cal_fetch)
);

// File: tb/tb_pc_sequencer.sv
// Bench: vector table walk, then directed reset, oscillator-mode and wrap tests.
module tb_pc_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_mode = 1'b0;
    logic        adv_en = 1'b0;
    logic        jmp_strobe = 1'b0;
    logic [8:0]  jmp_field = '0;
    logic        pg_wr = 1'b0;
    logic [1:0]  pg_wdata = '0;
    logic [10:0] fetch_addr;
    logic [1:0]  page_sel;
    logic        cal_fetch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Vector: adv, jmp, field[9], pgwr, pgdata[2] | exp addr[11], exp page[2], exp cal
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 9'h005, 1'b0, 2'd0, 11'h005, 2'd0, 1'b0}, // R5 jump at reset vector
        {1'b1, 1'b0, 9'h000, 1'b0, 2'd0, 11'h006, 2'd0, 1'b0}, // R3 step
        {1'b0, 1'b1, 9'h1FF, 1'b0, 2'd0, 11'h006, 2'd0, 1'b0}, // R9 strobe ignored
        {1'b0, 1'b0, 9'h000, 1'b1, 2'd2, 11'h006, 2'd2, 1'b0}, // R6 page write, addr kept
        {1'b1, 1'b1, 9'h010, 1'b0, 2'd0, 11'h410, 2'd2, 1'b0}, // R4 paged jump
        {1'b1, 1'b1, 9'h020, 1'b1, 2'd3, 11'h420, 2'd3, 1'b0}, // R6 old page used
        {1'b1, 1'b1, 9'h1FF, 1'b0, 2'd0, 11'h7FF, 2'd3, 1'b0}, // R4 jump to top
        {1'b1, 1'b0, 9'h000, 1'b0, 2'd0, 11'h000, 2'd3, 1'b0}, // R3 wrap
        {1'b1, 1'b0, 9'h000, 1'b0, 2'd0, 11'h001, 2'd3, 1'b0}, // R3 step
        {1'b0, 1'b0, 9'h000, 1'b0, 2'd0, 11'h001, 2'd3, 1'b0}  // R2 hold
    };

    pc_sequencer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_mode   (osc_mode),
        .adv_en     (adv_en),
        .jmp_strobe (jmp_strobe),
        .jmp_field  (jmp_field),
        .pg_wr      (pg_wr),
        .pg_wdata   (pg_wdata),
        .fetch_addr (fetch_addr),
        .page_sel   (page_sel),
        .cal_fetch  (cal_fetch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [10:0] ea,
                         input logic [1:0] ep, input logic ec);
        checks++;
        if (fetch_addr !== ea || page_sel !== ep || cal_fetch !== ec) begin
            errors++;
            $display("FAIL %s: addr=%h page=%0d cal=%b expected addr=%h page=%0d cal=%b",
                     req, fetch_addr, page_sel, cal_fetch, ea, ep, ec);
        end
    endtask

    // Drive on the falling edge, take one rising edge, sample on the next falling edge
    task automatic cycle(input logic a, input logic j, input logic [8:0] f,
                         input logic w, input logic [1:0] d);
        adv_en = a; jmp_strobe = j; jmp_field = f; pg_wr = w; pg_wdata = d;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic osc);
        rst_n = 1'b0; osc_mode = osc;
        adv_en = 1'b0; jmp_strobe = 1'b0; pg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        check("R1 reset state", 11'h7FF, 2'd0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            cycle(VEC[i][27], VEC[i][26], VEC[i][25:17], VEC[i][16], VEC[i][15:14]);
            check($sformatf("vector %0d (R2-R6,R9 table)", i),
                  VEC[i][13:3], VEC[i][2:1], VEC[i][0]);
        end

        // R1: reset with page 3 held returns to page 0 at top
        do_reset(1'b0);
        check("R1 reset clears page", 11'h7FF, 2'd0, 1'b0);

        // R3: sequential flow from the reset vector wraps to 0
        cycle(1'b1, 1'b0, 9'h000, 1'b0, 2'd0);
        check("R3 wrap from reset vector", 11'h000, 2'd0, 1'b0);

        // R7 and R8: oscillator mode
        do_reset(1'b1);
        check("R7 calibration flag after reset", 11'h7FF, 2'd0, 1'b1);
        cycle(1'b0, 1'b1, 9'h055, 1'b0, 2'd0);
        check("R7 flag held without advance", 11'h7FF, 2'd0, 1'b1);
        cycle(1'b1, 1'b1, 9'h055, 1'b0, 2'd0);
        check("R8 calibration word falls through to 0", 11'h000, 2'd0, 1'b0);
        cycle(1'b1, 1'b1, 9'h1FF, 1'b0, 2'd0);
        check("R4 jump honoured after calibration", 11'h1FF, 2'd0, 1'b0);
        cycle(1'b1, 1'b1, 9'h1FF, 1'b1, 2'd3);
        check("R4 jump to page0 top with page write pending", 11'h1FF, 2'd3, 1'b0);
        cycle(1'b1, 1'b1, 9'h1FF, 1'b0, 2'd0);
        check("R7 no flag at top after advance", 11'h7FF, 2'd3, 1'b0);

        // R7: oscillator mode off gives no flag at the reset vector
        do_reset(1'b0);
        check("R7 no flag without oscillator mode", 11'h7FF, 2'd0, 1'b0);
        cycle(1'b1, 1'b1, 9'h0AA, 1'b0, 2'd0);
        check("R5 jump from reset vector lands in page 0", 11'h0AA, 2'd0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule